// File: doc/BRIEF.md
# Segment Display RAM Controller

This block sits behind a serial byte receiver in a small segment-LCD driver. Each time a complete byte arrives, the receiver presents it for one clock cycle with a flag that says whether it is display data or a command. The controller keeps a 32-location, 4-bit display store and a 5-bit write pointer that moves by itself. It also holds the display mode, which the waveform generator uses to show the store, force every segment lit, or blank the panel.

A data byte fills two neighbouring locations: its upper nibble at the pointer and its lower nibble one place after it. The pointer then moves forward by two. Commands can load the pointer, write a single nibble and advance by one, select one of the three display modes, or return the block to its power-up state. The pointer wraps from location 31 to location 0. The whole store is presented as a flat 128-bit vector: location `a`, common line `c` sits at bit `4*a + c`.

Top module: `segram_ctrl`

## Requirements
- R1: After the asynchronous reset, every bit of `mem_view` is 0, `disp_mode` is 2'b10 (blank), and the write pointer is 0.
- R2: A byte accepted with `byte_is_cmd` low stores bits 7:4 at the pointer and bits 3:0 at pointer+1, then advances the pointer by 2.
- R3: A command whose bits 7:5 are 3'b100 stores bits 3:0 at the pointer and advances the pointer by 1. Bit 4 is ignored and no other location changes.
- R4: A command whose bits 7:5 are 3'b000 loads the pointer with bits 4:0.
- R5: Pointer arithmetic is modulo 32. A data byte at location 31 puts its low nibble at location 0, and a nibble write at location 31 leaves the pointer at 0.
- R6: Commands with bits 7:5 of 3'b001, 3'b010 and 3'b011 set `disp_mode` to 2'b01 (all lit), 2'b10 (blank) and 2'b00 (show store), leaving the store and the pointer untouched. `disp_mode` never reads 2'b11.
- R7: A command with bits 7:5 of 3'b110 sets `disp_mode` to 2'b10 and the pointer to 0, and leaves the store unchanged.
- R8: Commands with bits 7:5 of 3'b101 or 3'b111 change neither the store, nor the pointer, nor the mode.
- R9: While `byte_vld` is low, the store, the pointer and the mode hold, whatever `byte_data` and `byte_is_cmd` carry.
- R10: The effect of an accepted byte is visible on `mem_view` and `disp_mode` right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| byte_vld | input | 1 | One-cycle strobe: a complete byte is present |
| byte_is_cmd | input | 1 | 1 = command byte, 0 = display data byte |
| byte_data | input | 8 | Received byte, bit 7 first on the serial line |
| mem_view | output | 128 | Whole store; bit 4*addr+com |
| disp_mode | output | 2 | 00 show store, 01 all lit, 10 blank |

## Verification
The assertions assume that `byte_is_cmd` and `byte_data` are valid whenever `byte_vld` is high, and that a byte lasts for exactly the one cycle in which the strobe is high. The receiver upstream guarantees this. The stimulus changes inputs only on the falling clock edge and raises the strobe for a single cycle per byte. Between bytes it drives junk data with the strobe low, so the hold requirement is exercised under hostile inputs, while the other properties see only well-formed strobes.

// File: rtl/segram_pkg.sv
package segram_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_ALL_ON  = 2'b01,
    MODE_ALL_OFF = 2'b10
  } disp_mode_e;

  localparam logic [2:0] OP_ADDR   = 3'b000;
  localparam logic [2:0] OP_ON     = 3'b001;
  localparam logic [2:0] OP_OFF    = 3'b010;
  localparam logic [2:0] OP_NORMAL = 3'b011;
  localparam logic [2:0] OP_NIBBLE = 3'b100;
  localparam logic [2:0] OP_RESET  = 3'b110;

endpackage

// File: rtl/segram_decode.sv
module segram_decode
  import segram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              byte_vld,
  input  logic              byte_is_cmd,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              w0_en,
  output logic [NIB_W-1:0]  w0_dat,
  output logic              w1_en,
  output logic [NIB_W-1:0]  w1_dat,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_val,
  output logic [1:0]        step,
  output logic              mode_en,
  output disp_mode_e        mode_val
);

  logic [2:0] op;
  assign op = byte_data[BYTE_W-1 -: 3];

  always_comb begin
    w0_en    = 1'b0;
    w0_dat   = '0;
    w1_en    = 1'b0;
    w1_dat   = '0;
    ld_en    = 1'b0;
    ld_val   = '0;
    step     = 2'd0;
    mode_en  = 1'b0;
    mode_val = MODE_NORMAL;
    if (byte_vld) begin
      if (!byte_is_cmd) begin
        w0_en  = 1'b1;
        w0_dat = byte_data[BYTE_W-1 -: NIB_W];
        w1_en  = 1'b1;
        w1_dat = byte_data[NIB_W-1:0];
        step   = 2'd2;
      end else begin
        case (op)
          OP_ADDR: begin
            ld_en  = 1'b1;
            ld_val = byte_data[ADDR_W-1:0];
          end
          OP_NIBBLE: begin
            w0_en  = 1'b1;
            w0_dat = byte_data[NIB_W-1:0];
            step   = 2'd1;
          end
          OP_ON: begin
            mode_en  = 1'b1;
            mode_val = MODE_ALL_ON;
          end
          OP_OFF: begin
            mode_en  = 1'b1;
            mode_val = MODE_ALL_OFF;
          end
          OP_NORMAL: begin
            mode_en  = 1'b1;
            mode_val = MODE_NORMAL;
          end
          OP_RESET: begin
            mode_en  = 1'b1;
            mode_val = MODE_ALL_OFF;
            ld_en    = 1'b1;
            ld_val   = '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/segram_addr.sv
module segram_addr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] addr_d;
  logic              addr_ce;

  always_comb begin
    addr_ce = ld_en || (step != 2'd0);
    if (ld_en) addr_d = ld_val;
    else       addr_d = addr_q + ADDR_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_ce) addr_q <= addr_d;
  end

endmodule

// File: rtl/segram_mem.sv
module segram_mem #(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int VIEW_W = DEPTH * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              w0_en,
  input  logic [NIB_W-1:0]  w0_dat,
  input  logic              w1_en,
  input  logic [NIB_W-1:0]  w1_dat,
  output logic [VIEW_W-1:0] mem_view
);

  logic [ADDR_W-1:0] nxt_addr;
  assign nxt_addr = cur_addr + ADDR_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    logic [NIB_W-1:0] loc_q;
    logic [NIB_W-1:0] loc_d;
    logic             loc_ce;
    logic             hit0;
    logic             hit1;

    always_comb begin
      hit0   = w0_en && (cur_addr == ADDR_W'(i));
      hit1   = w1_en && (nxt_addr == ADDR_W'(i));
      loc_ce = hit0 || hit1;
      loc_d  = hit0 ? w0_dat : w1_dat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      loc_q <= '0;
      else if (loc_ce) loc_q <= loc_d;
    end

    assign mem_view[i*NIB_W +: NIB_W] = loc_q;
  end

endmodule

// File: rtl/segram_mode.sv
module segram_mode
  import segram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_en,
  input  disp_mode_e mode_val,
  output disp_mode_e mode_q
);

  disp_mode_e mode_d;

  always_comb begin
    mode_d = mode_en ? mode_val : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_ALL_OFF;
    else if (mode_en) mode_q <= mode_d;
  end

endmodule

// File: rtl/segram_ctrl.sv
module segram_ctrl
  import segram_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int VIEW_W = (1 << ADDR_W) * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic              byte_is_cmd,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [VIEW_W-1:0] mem_view,
  output logic [1:0]        disp_mode
);

  logic              w0_en;
  logic [NIB_W-1:0]  w0_dat;
  logic              w1_en;
  logic [NIB_W-1:0]  w1_dat;
  logic              ld_en;
  logic [ADDR_W-1:0] ld_val;
  logic [1:0]        step;
  logic              mode_en;
  disp_mode_e        mode_val;
  disp_mode_e        mode_q;
  logic [ADDR_W-1:0] cur_addr;

  segram_decode #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_decode (
    .byte_vld    (byte_vld),
    .byte_is_cmd (byte_is_cmd),
    .byte_data   (byte_data),
    .w0_en       (w0_en),
    .w0_dat      (w0_dat),
    .w1_en       (w1_en),
    .w1_dat      (w1_dat),
    .ld_en       (ld_en),
    .ld_val      (ld_val),
    .step        (step),
    .mode_en     (mode_en),
    .mode_val    (mode_val)
  );

  segram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_en  (ld_en),
    .ld_val (ld_val),
    .step   (step),
    .addr_q (cur_addr)
  );

  segram_mem #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_addr (cur_addr),
    .w0_en    (w0_en),
    .w0_dat   (w0_dat),
    .w1_en    (w1_en),
    .w1_dat   (w1_dat),
    .mem_view (mem_view)
  );

  segram_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .mode_val (mode_val),
    .mode_q   (mode_q)
  );

  assign disp_mode = mode_q;

endmodule

// File: rtl/segram_ctrl_chk.sv
module segram_ctrl_chk #(
  parameter int ADDR_W = 5,
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W,
  localparam int VIEW_W = (1 << ADDR_W) * NIB_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              byte_is_cmd,
  input logic [BYTE_W-1:0] byte_data,
  input logic [VIEW_W-1:0] mem_view,
  input logic [1:0]        disp_mode,
  input logic [ADDR_W-1:0] cur_addr
);

  logic [2:0] op;
  logic       is_cmd_vld;
  assign op         = byte_data[BYTE_W-1 -: 3];
  assign is_cmd_vld = byte_vld && byte_is_cmd;

  a_r2_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld && !byte_is_cmd |=> cur_addr == $past(cur_addr) + ADDR_W'(2));

  a_r3_nibble_step: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b100 |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

  a_r4_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b000 |=> cur_addr == $past(byte_data[ADDR_W-1:0]));

  a_r6_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b001 |=> disp_mode == 2'b01 && $stable(mem_view));

  a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b010 |=> disp_mode == 2'b10 && $stable(mem_view));

  a_r6_normal: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b011 |=> disp_mode == 2'b00 && $stable(cur_addr));

  a_r6_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    disp_mode != 2'b11);

  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && op == 3'b110 |=> disp_mode == 2'b10 && cur_addr == '0 && $stable(mem_view));

  a_r8_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd_vld && (op == 3'b101 || op == 3'b111)
      |=> $stable(mem_view) && $stable(disp_mode) && $stable(cur_addr));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(mem_view) && $stable(disp_mode) && $stable(cur_addr));

endmodule

bind segram_ctrl segram_ctrl_chk #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_chk (.*);

// File: tb/segram_ctrl_bench.sv
module segram_ctrl_bench;

  logic         clk;
  logic         rst_n;
  logic         byte_vld;
  logic         byte_is_cmd;
  logic [7:0]   byte_data;
  logic [127:0] mem_view;
  logic [1:0]   disp_mode;

  int checks;
  int failures;
  bit done;

  logic [3:0] m_mem [32];
  logic [4:0] m_addr;
  logic [1:0] m_mode;

  logic [127:0] q_view [$];
  logic [1:0]   q_mode [$];
  string        q_tag  [$];

  segram_ctrl u_segram_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_vld    (byte_vld),
    .byte_is_cmd (byte_is_cmd),
    .byte_data   (byte_data),
    .mem_view    (mem_view),
    .disp_mode   (disp_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [127:0] model_view();
    logic [127:0] v;
    for (int a = 0; a < 32; a++) v[a*4 +: 4] = m_mem[a];
    return v;
  endfunction

  task automatic check_now(input string tag);
    checks++;
    if (mem_view !== model_view()) begin
      failures++;
      $display("FAIL %s view: actual=%h expected=%h", tag, mem_view, model_view());
    end
    checks++;
    if (disp_mode !== m_mode) begin
      failures++;
      $display("FAIL %s mode: actual=%b expected=%b", tag, disp_mode, m_mode);
    end
  endtask

  // Driver: present one byte for one cycle, update the model, queue the expectation.
  task automatic send(input logic cmd, input logic [7:0] d, input string tag);
    @(negedge clk);
    byte_vld    = 1'b1;
    byte_is_cmd = cmd;
    byte_data   = d;
    if (!cmd) begin
      m_mem[m_addr]        = d[7:4];
      m_mem[m_addr + 5'd1] = d[3:0];
      m_addr               = m_addr + 5'd2;
    end else begin
      case (d[7:5])
        3'b000: m_addr = d[4:0];
        3'b100: begin m_mem[m_addr] = d[3:0]; m_addr = m_addr + 5'd1; end
        3'b001: m_mode = 2'b01;
        3'b010: m_mode = 2'b10;
        3'b011: m_mode = 2'b00;
        3'b110: begin m_mode = 2'b10; m_addr = 5'd0; end
        default: ;
      endcase
    end
    q_view.push_back(model_view());
    q_mode.push_back(m_mode);
    q_tag.push_back(tag);
    @(negedge clk);
    byte_vld    = 1'b0;
  endtask

  // Monitor: one cycle after each accepted byte (R10 latency), pop and compare.
  initial begin
    forever begin
      logic acc;
      @(posedge clk);
      acc = byte_vld;
      @(negedge clk);
      if (acc) begin
        checks++;
        if (q_tag.size() == 0) begin
          failures++;
          $display("FAIL R10 unexpected byte: actual=accepted expected=none");
        end else begin
          logic [127:0] ev;
          logic [1:0]   em;
          string        et;
          ev = q_view.pop_front();
          em = q_mode.pop_front();
          et = q_tag.pop_front();
          if (mem_view !== ev) begin
            failures++;
            $display("FAIL %s view: actual=%h expected=%h", et, mem_view, ev);
          end
          checks++;
          if (disp_mode !== em) begin
            failures++;
            $display("FAIL %s mode: actual=%b expected=%b", et, disp_mode, em);
          end
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; byte_vld = 1'b0; byte_is_cmd = 1'b0; byte_data = 8'h00;
    for (int a = 0; a < 32; a++) m_mem[a] = 4'h0;
    m_addr = 5'd0; m_mode = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R1 reset state");

    send(1'b0, 8'hA5, "R2 data byte at 0 (R1 pointer 0)");
    send(1'b0, 8'h3C, "R2 data byte at 2");
    send(1'b1, 8'h9E, "R3 nibble write bit4 set");
    send(1'b0, 8'h71, "R3 pointer +1 then R2");
    send(1'b1, 8'h1F, "R4 address set 31");
    send(1'b0, 8'hB6, "R5 data byte wraps low nibble to 0");
    send(1'b1, 8'h82, "R5 pointer now 1 after wrap");
    send(1'b1, 8'h1F, "R4 address set 31 again");
    send(1'b1, 8'h84, "R5 nibble at 31");
    send(1'b1, 8'h89, "R5 nibble after wrap lands at 0");
    send(1'b1, 8'h3F, "R6 all lit");
    send(1'b1, 8'h5A, "R6 blank");
    send(1'b1, 8'h60, "R6 show store");
    send(1'b1, 8'hA7, "R8 opcode 101 ignored");
    send(1'b1, 8'hFF, "R8 opcode 111 ignored");
    send(1'b0, 8'h12, "R8 pointer unchanged by ignored ops");
    send(1'b1, 8'h30, "R6 all lit before reset");
    send(1'b1, 8'hC5, "R7 reset command");
    send(1'b0, 8'hDE, "R7 pointer back at 0, store kept");

    // R9: junk on data lines while the strobe stays low.
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      byte_is_cmd = k[0];
      byte_data   = 8'h20 + 8'(k * 37);
      @(negedge clk);
      check_now("R9 idle hold");
    end
    send(1'b0, 8'h4B, "R9 pointer held through idle");
    send(1'b1, 8'h1E, "R4 address set 30");
    send(1'b0, 8'hC3, "R2 data byte at 30");

    repeat (3) @(negedge clk);
    checks++;
    if (q_tag.size() != 0) begin
      failures++;
      $display("FAIL R10 pending results: actual=%0d expected=0", q_tag.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule